// File: doc/BRIEF.md
# Accumulator Rotate and Decimal-Adjust Unit

This unit computes the single-byte accumulator operations whose only inputs are the accumulator and the flag byte. There are four rotates (circular and through-carry, left and right), the decimal correction after packed-BCD addition or subtraction, a bitwise complement, and the two carry-flag operations (force carry, invert carry). Each request carries an operation code, an accumulator byte and a flag byte. The unit returns the new accumulator and the new flag byte. The two undocumented flag bits (X at bit 3, Y at bit 5) are reproduced exactly.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream through a single output register. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure on the output therefore stalls the input combinationally, and no result is ever dropped or overwritten.

Top module: `acc_unit`

## Requirements
- R1: A request is taken on a rising edge where in_valid and in_ready are both high, and its result appears with out_valid on the following cycle. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid, out_acc and out_flags hold their values.
- R2: A synchronous active-high rst clears out_valid, out_acc and out_flags to zero, including a result that is still waiting to be taken.
- R3: Operation codes are: 0 rotate left circular, 1 rotate left through carry, 2 rotate right circular, 3 rotate right through carry, 4 decimal adjust, 5 complement, 6 set carry, 7 complement carry. Flag byte bits are: C=0, N=1, PV=2, X=3, H=4, Y=5, Z=6, S=7.
- R4: A circular rotate left copies bit 7 into both bit 0 and C. A circular rotate right copies bit 0 into both bit 7 and C.
- R5: A rotate through carry fills the vacated end with the incoming C, and the bit pushed out becomes the new C.
- R6: Every rotate clears H and N, and sets X and Y to bits 3 and 5 of the rotated accumulator.
- R7: Decimal adjust forms a correction of 0x06 if H is set or the low nibble exceeds 9. It adds 0x60 to the correction if C is set or the accumulator exceeds 0x99. The correction is subtracted when N is set and added otherwise, modulo 256.
- R8: After decimal adjust: S, Z, X and Y follow the result. H is bit 4 of (input XOR correction XOR result). PV is set for even parity of the result. N is unchanged. C is the input C OR'd with whether the 0x60 part was applied.
- R9: Complement inverts the accumulator, sets H and N, and takes X and Y from the inverted byte. C is unchanged.
- R10: Set carry leaves the accumulator unchanged, sets C, clears H and N. It sets X and Y together only when accumulator bits 3 and 5 are both one, and clears both otherwise.
- R11: Complement carry leaves the accumulator unchanged, moves the incoming C into H, inverts C and clears N. X and Y follow the same rule as in R10.
- R12: S, Z and PV pass through unchanged for every operation except decimal adjust.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code (R3) |
| in_acc | input | 8 | Accumulator operand |
| in_flags | input | 8 | Flag byte operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_acc | output | 8 | New accumulator |
| out_flags | output | 8 | New flag byte |

## Verification
The hardest case to reach is decimal adjust with flag combinations that ordinary arithmetic seldom leaves behind. Examples are N set together with an accumulator above 0x99, or H set with a low nibble already above 9. These are exactly the cases where the correction, the new H and the carry diverge from the common path. Because the flag byte is an input, the bench drives every accumulator value against all eight combinations of H, N and C directly. A long random phase follows, in which the consumer withholds out_ready about a quarter of the time. That makes results sit stalled in the output register while the next request waits at the input.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;
  localparam int DW = 8;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ROL_C  = 3'd0,
    OP_ROL_T  = 3'd1,
    OP_ROR_C  = 3'd2,
    OP_ROR_T  = 3'd3,
    OP_DECADJ = 3'd4,
    OP_INVERT = 3'd5,
    OP_SETC   = 3'd6,
    OP_TOGC   = 3'd7
  } acc_op_e;

  // flag byte positions, decoded by neighbouring logic
  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_X  = 3;
  localparam int FB_H  = 4;
  localparam int FB_Y  = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;
endpackage

// File: rtl/acc_rotate.sv
module acc_rotate
  import acc_unit_pkg::*;
(
  input  acc_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] f,
  output logic [DW-1:0] res,
  output logic [DW-1:0] fl
);
  logic cout;

  always_comb begin
    res  = a;
    cout = f[FB_C];
    case (op)
      OP_ROL_C: begin res = {a[DW-2:0], a[DW-1]};    cout = a[DW-1]; end
      OP_ROL_T: begin res = {a[DW-2:0], f[FB_C]};    cout = a[DW-1]; end
      OP_ROR_C: begin res = {a[0], a[DW-1:1]};       cout = a[0];    end
      OP_ROR_T: begin res = {f[FB_C], a[DW-1:1]};    cout = a[0];    end
      default:  begin res = a;                       cout = f[FB_C]; end
    endcase
    fl       = f;
    fl[FB_H] = 1'b0;
    fl[FB_N] = 1'b0;
    fl[FB_C] = cout;
    fl[FB_X] = res[3];
    fl[FB_Y] = res[5];
  end
endmodule

// File: rtl/acc_decadj.sv
module acc_decadj
  import acc_unit_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] f,
  output logic [DW-1:0] res,
  output logic [DW-1:0] fl
);
  logic          lo_fix, hi_fix;
  logic [DW-1:0] corr;
  logic [DW-1:0] mix;

  always_comb begin
    lo_fix = f[FB_H] | (a[3:0] > 4'd9);
    hi_fix = f[FB_C] | (a > 8'h99);
    corr   = {1'b0, hi_fix, hi_fix, 2'b00, lo_fix, lo_fix, 1'b0};
    res    = f[FB_N] ? (a - corr) : (a + corr);
    mix    = a ^ corr ^ res;
    fl        = '0;
    fl[FB_S]  = res[7];
    fl[FB_Z]  = (res == '0);
    fl[FB_Y]  = res[5];
    fl[FB_H]  = mix[4];
    fl[FB_X]  = res[3];
    fl[FB_PV] = ~^res;
    fl[FB_N]  = f[FB_N];
    fl[FB_C]  = f[FB_C] | hi_fix;
  end
endmodule

// File: rtl/acc_flagop.sv
module acc_flagop
  import acc_unit_pkg::*;
(
  input  acc_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] f,
  output logic [DW-1:0] res,
  output logic [DW-1:0] fl
);
  logic both35;

  always_comb begin
    both35 = a[3] & a[5];
    res    = a;
    fl     = f;
    case (op)
      OP_INVERT: begin
        res      = ~a;
        fl[FB_H] = 1'b1;
        fl[FB_N] = 1'b1;
        fl[FB_X] = ~a[3];
        fl[FB_Y] = ~a[5];
      end
      OP_SETC: begin
        fl[FB_C] = 1'b1;
        fl[FB_H] = 1'b0;
        fl[FB_N] = 1'b0;
        fl[FB_X] = both35;
        fl[FB_Y] = both35;
      end
      OP_TOGC: begin
        fl[FB_H] = f[FB_C];
        fl[FB_C] = ~f[FB_C];
        fl[FB_N] = 1'b0;
        fl[FB_X] = both35;
        fl[FB_Y] = both35;
      end
      default: begin
        res = a;
        fl  = f;
      end
    endcase
  end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_unit_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_acc,
  input  logic [DW-1:0]  in_flags,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_acc,
  output logic [DW-1:0]  out_flags
);
  acc_op_e       op;
  logic [DW-1:0] rot_a, rot_f, dec_a, dec_f, flg_a, flg_f;
  logic [DW-1:0] nxt_a, nxt_f;
  logic          take;

  assign op       = acc_op_e'(in_op);
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  acc_rotate u_rot (.op(op), .a(in_acc), .f(in_flags), .res(rot_a), .fl(rot_f));
  acc_decadj u_dec (.a(in_acc), .f(in_flags), .res(dec_a), .fl(dec_f));
  acc_flagop u_flg (.op(op), .a(in_acc), .f(in_flags), .res(flg_a), .fl(flg_f));

  // bit 2 of the code separates the rotate family from the rest
  always_comb begin
    if (!in_op[2]) begin
      nxt_a = rot_a;
      nxt_f = rot_f;
    end else if (op == OP_DECADJ) begin
      nxt_a = dec_a;
      nxt_f = dec_f;
    end else begin
      nxt_a = flg_a;
      nxt_f = flg_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_acc   <= nxt_a;
        out_flags <= nxt_f;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_unit_checker.sv
module acc_unit_checker
  import acc_unit_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [OPW-1:0] in_op,
  input logic [DW-1:0]  in_acc,
  input logic [DW-1:0]  in_flags,
  input logic           out_valid,
  input logic           out_ready,
  input logic [DW-1:0]  out_acc,
  input logic [DW-1:0]  out_flags
);
  logic fire;
  assign fire = in_valid & in_ready;

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_flags));

  assert_fill_R1: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  assert_clear_R2: assert property (@(posedge clk)
    rst |=> !out_valid && out_acc == '0 && out_flags == '0);

  assert_rlc_R4: assert property (@(posedge clk) disable iff (rst)
    fire && in_op == 3'(OP_ROL_C) |=> out_flags[FB_C] == $past(in_acc[7]) && out_acc[0] == $past(in_acc[7]));

  assert_rrt_R5: assert property (@(posedge clk) disable iff (rst)
    fire && in_op == 3'(OP_ROR_T) |=> out_acc[7] == $past(in_flags[FB_C]) && out_flags[FB_C] == $past(in_acc[0]));

  assert_rotclr_R6: assert property (@(posedge clk) disable iff (rst)
    fire && !in_op[2] |=> !out_flags[FB_H] && !out_flags[FB_N]);

  assert_daa_R8: assert property (@(posedge clk) disable iff (rst)
    fire && in_op == 3'(OP_DECADJ) |=> out_flags[FB_N] == $past(in_flags[FB_N]) && out_flags[FB_PV] == ~^out_acc);

  assert_cpl_R9: assert property (@(posedge clk) disable iff (rst)
    fire && in_op == 3'(OP_INVERT) |=> out_acc == ~$past(in_acc) && out_flags[FB_H] && out_flags[FB_N]);

  assert_scf_R10: assert property (@(posedge clk) disable iff (rst)
    fire && in_op == 3'(OP_SETC) |=> out_flags[FB_C] && !out_flags[FB_H] && !out_flags[FB_N]);

  assert_ccf_R11: assert property (@(posedge clk) disable iff (rst)
    fire && in_op == 3'(OP_TOGC) |=> out_flags[FB_C] != $past(in_flags[FB_C]) && out_flags[FB_H] == $past(in_flags[FB_C]));

  assert_szp_R12: assert property (@(posedge clk) disable iff (rst)
    fire && in_op != 3'(OP_DECADJ) |=> out_flags[FB_S] == $past(in_flags[FB_S]) && out_flags[FB_Z] == $past(in_flags[FB_Z]) && out_flags[FB_PV] == $past(in_flags[FB_PV]));
endmodule

bind acc_unit acc_unit_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_acc(in_acc), .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
  .out_acc(out_acc), .out_flags(out_flags)
);

// File: tb/tb_acc_unit.sv
module tb_acc_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [2:0] in_op;
  logic [7:0] in_acc, in_flags, out_acc, out_flags;

  always #4 clk = ~clk;

  acc_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_acc(in_acc), .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_acc(out_acc), .out_flags(out_flags)
  );

  int    checks = 0, errors = 0, cycles = 0;
  bit    finished = 0, hold_ready = 1;
  int    qa[$], qf[$];
  string qta[$], qtf[$];
  bit    stall_prev = 0;
  int    held_a, held_f;

  function automatic int even_par(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  // behavioural reference, written from the requirements
  function automatic void model(input int op, input int a, input int f,
                                output int ra, output int rf,
                                output string ta, output string tf);
    int c, h, n, corr, xy;
    c = f & 1; n = (f >> 1) & 1; h = (f >> 4) & 1;
    xy = ((a & 'h28) == 'h28) ? 'h28 : 0;
    ra = a; rf = f; ta = ""; tf = "";
    case (op)
      0: begin ra = ((a * 2) % 256) + a / 128;   rf = (f & 'hC4) | (a / 128); ta = "R4"; end
      1: begin ra = ((a * 2) % 256) + c;         rf = (f & 'hC4) | (a / 128); ta = "R5"; end
      2: begin ra = a / 2 + (a % 2) * 128;       rf = (f & 'hC4) | (a % 2);   ta = "R4"; end
      3: begin ra = a / 2 + c * 128;             rf = (f & 'hC4) | (a % 2);   ta = "R5"; end
      4: begin
        corr = 0;
        if (h == 1 || (a % 16) > 9) corr += 6;
        if (c == 1 || a > 153) corr += 96;
        ra = (n == 1) ? (a - corr + 256) % 256 : (a + corr) % 256;
        rf = (ra & 'hA8) | ((ra == 0) ? 'h40 : 0) | ((a ^ corr ^ ra) & 'h10)
           | (even_par(ra) * 4) | (n * 2) | ((c == 1 || corr >= 96) ? 1 : 0);
        ta = "R7"; tf = "R8";
      end
      5: begin ra = 255 - a; rf = (f & 'hC5) | 'h12 | (ra & 'h28); ta = "R9"; tf = "R9 R12"; end
      6: begin rf = (f & 'hC4) | xy | 1; ta = "R10"; tf = "R10 R12"; end
      default: begin rf = (f & 'hC4) | xy | (c * 16) | (1 - c); ta = "R11"; tf = "R11 R12"; end
    endcase
    if (op < 4) begin
      rf = rf | (ra & 'h28);
      tf = "R6 R12";
    end
  endfunction

  task automatic fail_line(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) fail_line(req, act, exp);
  endtask

  // consumer: random back-pressure, driven on the falling edge
  always @(negedge clk) begin
    if (hold_ready) out_ready = 1'b0;
    else            out_ready = ($urandom % 4) != 0;
  end

  // monitor: samples one time unit after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst) begin
      stall_prev = 0;
    end else if (!finished) begin
      if (stall_prev) begin
        chk("R1 stall valid", int'(out_valid), 1);
        chk("R1 stall acc", int'(out_acc), held_a);
        chk("R1 stall flags", int'(out_flags), held_f);
      end
      chk("R1 in_ready", int'(in_ready), int'(!out_valid || out_ready));
      stall_prev = out_valid && !out_ready;
      held_a = out_acc; held_f = out_flags;
      if (out_valid && out_ready) begin
        if (qa.size() == 0) begin
          checks++;
          fail_line("R1 unexpected result", int'(out_acc), 0);
        end else begin
          chk(qta[0], int'(out_acc), qa[0]);
          chk({"R3 ", qtf[0]}, int'(out_flags), qf[0]);
          void'(qa.pop_front()); void'(qf.pop_front());
          void'(qta.pop_front()); void'(qtf.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        int ra, rf; string ta, tf;
        model(int'(in_op), int'(in_acc), int'(in_flags), ra, rf, ta, tf);
        qa.push_back(ra); qf.push_back(rf); qta.push_back(ta); qtf.push_back(tf);
      end
    end
  end

  task automatic send(input int op, input int a, input int f);
    bit took;
    if ($urandom % 4 == 0) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1; in_op = 3'(op); in_acc = 8'(a); in_flags = 8'(f);
    took = 0;
    while (!took) begin
      #1;
      took = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<150000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_acc = '0; in_flags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R2 reset out_valid", int'(out_valid), 0);
    chk("R2 reset out_acc", int'(out_acc), 0);
    chk("R2 reset out_flags", int'(out_flags), 0);
    chk("R1 reset in_ready", int'(in_ready), 1);
    @(negedge clk);

    // a result left waiting, then removed by reset
    send(5, 'h3C, 'h00);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R2 pending cleared valid", int'(out_valid), 0);
    chk("R2 pending cleared acc", int'(out_acc), 0);
    chk("R2 pending cleared flags", int'(out_flags), 0);
    qa.delete(); qf.delete(); qta.delete(); qtf.delete();
    @(negedge clk);
    hold_ready = 0;

    // decimal adjust: every byte against every H/N/C combination (R7, R8)
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 8; k++) begin
        int f;
        f = (k & 1) | ((k & 2) ? 2 : 0) | ((k & 4) ? 16 : 0) | ($urandom & 'hEC);
        send(4, a, f);
      end
    end

    // directed corners for R10 and R11 (bits 3 and 5 alone or together)
    send(6, 'h28, 'h00); send(6, 'h08, 'hFF); send(6, 'h20, 'h00);
    send(7, 'h28, 'h01); send(7, 'h28, 'h00); send(7, 'h08, 'hFE);
    send(0, 'h80, 'h00); send(1, 'h80, 'h00); send(2, 'h01, 'h00); send(3, 'h00, 'h01);

    for (int i = 0; i < 3000; i++) send($urandom % 8, $urandom % 256, $urandom % 256);

    for (int w = 0; w < 200 && (qa.size() != 0 || out_valid); w++) @(negedge clk);
    checks++;
    if (qa.size() != 0) fail_line("R1 results outstanding", qa.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule